// File: doc/BRIEF.md
# Windowed PCIe Address Translation Unit

This block translates addresses between a host bus and a PCIe link through a set of programmable windows. There are `NUM_WIN` outbound windows, used for host-to-link traffic, and `NUM_WIN` inbound windows, used for link-to-host traffic. Software reaches every window through one shared group of registers. A window-select register chooses which window that group reads and writes. Each window holds:

- a 64-bit base,
- a 32-bit upper limit,
- a 64-bit target,
- two control words.

The first control word sets the window type: memory remap or configuration access. The second control word holds the enable bit. Writing the second control word commits the window's edited settings into the live copy that the lookup logic uses.

The lookup port is purely combinational. It takes a direction and a 64-bit address and returns:

- a hit flag,
- the index of the winning window,
- for a memory window, the remapped address,
- for a configuration window, the bus number, the device/function number and a 12-bit register offset.

When several enabled windows of the requested direction match, the lowest-numbered one wins.

Top module: `pcie_xlat_unit`

## Requirements
- R1: The window-select register sits at offset 0x900. Bit 31 picks the direction (1 = inbound, 0 = outbound) and bits 3:0 pick the window index. A read returns the full stored 32-bit value.
- R2: The selected window's registers sit at these offsets: control-1 at 0x904, control-2 at 0x908, base low at 0x90C, base high at 0x910, limit at 0x914, target low at 0x918, target high at 0x91C. A read returns the last value written to that window. If the index is NUM_WIN or more, writes are ignored and reads return 0. Unmapped offsets read 0.
- R3: Base and target are 64 bits wide and are written in 32-bit halves. Each write replaces only its own half.
- R4: Lookups see a window's edits only after its control-2 register is written. Control-2 bit 31 is the enable.
- R5: A window hits when it is enabled, the address is at least base, and the address is at most {base[63:32], limit}.
- R6: When control-1 bits 4:0 are 0, the window is a memory window. On a hit, lk_out_addr = target + (address - base) and lk_is_cfg = 0.
- R7: When control-1 bits 4:0 are non-zero, the window is a configuration window. A hit gives:
  - lk_is_cfg = 1
  - lk_bus = target[31:24]
  - lk_devfn = target[23:16]
  - lk_reg_off = (address - base) modulo 4096
  - lk_out_addr = 0
- R8: If more than one enabled window of the requested direction matches, the lowest index wins, and lk_win reports that index.
- R9: A lookup considers only windows of the direction given by lk_inbound.
- R10: After reset, every window has base 0, target 0, limit 0xFFFFFFFF, control-1 0 and control-2 0. The one exception is inbound window 0, whose control-2 is 0x80000000 (enabled). Inbound addresses below 2^32 therefore pass through unchanged.
- R11: On a miss, lk_hit, lk_win, lk_is_cfg, lk_out_addr, lk_bus, lk_devfn and lk_reg_off are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| lk_inbound | input | 1 | Lookup direction, 1 = inbound |
| lk_addr | input | 64 | Lookup address |
| lk_hit | output | 1 | A window matched |
| lk_win | output | 4 | Winning window index |
| lk_is_cfg | output | 1 | Winning window is a configuration window |
| lk_out_addr | output | 64 | Remapped address (memory windows) |
| lk_bus | output | 8 | Bus number (configuration windows) |
| lk_devfn | output | 8 | Device/function (configuration windows) |
| lk_reg_off | output | 12 | Configuration register offset |

## Verification
The assertions assume one register write per cycle at most. They also assume that cfg_addr is stable while cfg_wr is high. Under those assumptions, a live window can only change in the cycle its control-2 is written, and the select register can only change on a write to 0x900.

The lookup properties assume that lk_inbound and lk_addr are sampled only as combinational inputs, with no relation to the clock. The bench changes them only between clock edges and never while a register write is in flight. It programs every window only through the select-then-write sequence, with indexes both inside and outside the implemented range.

// File: rtl/pcie_xlat_pkg.sv
package pcie_xlat_pkg;

  localparam logic [11:0] OFF_SEL    = 12'h900;
  localparam logic [11:0] OFF_CTRL1  = 12'h904;
  localparam logic [11:0] OFF_CTRL2  = 12'h908;
  localparam logic [11:0] OFF_BASE_L = 12'h90C;
  localparam logic [11:0] OFF_BASE_H = 12'h910;
  localparam logic [11:0] OFF_LIMIT  = 12'h914;
  localparam logic [11:0] OFF_TGT_L  = 12'h918;
  localparam logic [11:0] OFF_TGT_H  = 12'h91C;

  localparam int IDX_W     = 4;
  localparam int CFG_OFF_W = 12;

  // editable copy, what software reads back
  typedef struct packed {
    logic [63:0] base;
    logic [63:0] target;
    logic [31:0] limit;
    logic [31:0] ctrl1;
    logic [31:0] ctrl2;
  } win_shadow_t;

  // committed copy, what the lookup uses
  typedef struct packed {
    logic        en;
    logic        is_cfg;
    logic [63:0] base;
    logic [63:0] target;
    logic [31:0] limit;
  } win_live_t;

  function automatic logic win_covers(win_live_t w, logic [63:0] a);
    return w.en && (a >= w.base) && (a <= {w.base[63:32], w.limit});
  endfunction

  function automatic logic [63:0] win_remap(win_live_t w, logic [63:0] a);
    return w.target + (a - w.base);
  endfunction

  function automatic logic [CFG_OFF_W-1:0] win_cfg_off(win_live_t w, logic [63:0] a);
    return a[CFG_OFF_W-1:0] - w.base[CFG_OFF_W-1:0];
  endfunction

  function automatic logic type_is_cfg(logic [31:0] ctrl1);
    return ctrl1[4:0] != 5'd0;
  endfunction

endpackage

// File: rtl/pcie_xlat_regs.sv
module pcie_xlat_regs
  import pcie_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [11:0]                        addr,
  input  logic [31:0]                        wdata,
  output logic [31:0]                        rdata,
  output logic [31:0]                        sel_o,
  output win_live_t [1:0][NUM_WIN-1:0]       live_o,
  output logic      [1:0][NUM_WIN-1:0]       commit_o
);

  localparam int CMP_W = IDX_W + 1;

  logic [31:0]      sel_q;
  logic             sel_dir;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_ok;
  win_shadow_t [1:0][NUM_WIN-1:0] shadow_all;
  win_shadow_t      rd_win;

  assign sel_dir = sel_q[31];
  assign sel_idx = sel_q[IDX_W-1:0];
  assign sel_ok  = {1'b0, sel_idx} < CMP_W'(NUM_WIN);
  assign sel_o   = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        sel_q <= '0;
    else if (wr_en && addr == OFF_SEL) sel_q <= wdata;
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam bit BOOT_EN = (d == 1) && (i == 0);
      win_shadow_t sh_q;
      win_live_t   lv_q;
      logic        me;
      logic        commit;

      assign me     = wr_en && sel_ok && (sel_dir == 1'(d)) && (sel_idx == IDX_W'(i));
      assign commit = me && (addr == OFF_CTRL2);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sh_q.base   <= '0;
          sh_q.target <= '0;
          sh_q.limit  <= '1;
          sh_q.ctrl1  <= '0;
          sh_q.ctrl2  <= BOOT_EN ? 32'h8000_0000 : 32'h0;
        end else if (me) begin
          case (addr)
            OFF_CTRL1:  sh_q.ctrl1         <= wdata;
            OFF_CTRL2:  sh_q.ctrl2         <= wdata;
            OFF_BASE_L: sh_q.base[31:0]    <= wdata;
            OFF_BASE_H: sh_q.base[63:32]   <= wdata;
            OFF_LIMIT:  sh_q.limit         <= wdata;
            OFF_TGT_L:  sh_q.target[31:0]  <= wdata;
            OFF_TGT_H:  sh_q.target[63:32] <= wdata;
            default: ;
          endcase
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lv_q.en     <= BOOT_EN;
          lv_q.is_cfg <= 1'b0;
          lv_q.base   <= '0;
          lv_q.target <= '0;
          lv_q.limit  <= '1;
        end else if (commit) begin
          lv_q.en     <= wdata[31];
          lv_q.is_cfg <= type_is_cfg(sh_q.ctrl1);
          lv_q.base   <= sh_q.base;
          lv_q.target <= sh_q.target;
          lv_q.limit  <= sh_q.limit;
        end
      end

      assign shadow_all[d][i] = sh_q;
      assign live_o[d][i]     = lv_q;
      assign commit_o[d][i]   = commit;
    end
  end

  always_comb begin
    rd_win = '0;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (sel_dir == 1'(d) && sel_idx == IDX_W'(i)) rd_win = shadow_all[d][i];
      end
    end
  end

  always_comb begin
    case (addr)
      OFF_SEL:    rdata = sel_q;
      OFF_CTRL1:  rdata = rd_win.ctrl1;
      OFF_CTRL2:  rdata = rd_win.ctrl2;
      OFF_BASE_L: rdata = rd_win.base[31:0];
      OFF_BASE_H: rdata = rd_win.base[63:32];
      OFF_LIMIT:  rdata = rd_win.limit;
      OFF_TGT_L:  rdata = rd_win.target[31:0];
      OFF_TGT_H:  rdata = rd_win.target[63:32];
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/pcie_xlat_match.sv
module pcie_xlat_match
  import pcie_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  win_live_t [NUM_WIN-1:0] wins,
  input  logic      [63:0]        addr,
  output logic      [NUM_WIN-1:0] match_o
);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign match_o[i] = win_covers(wins[i], addr);
  end

endmodule

// File: rtl/pcie_xlat_prio.sv
module pcie_xlat_prio
  import pcie_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic [NUM_WIN-1:0] match_i,
  output logic [NUM_WIN-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign any_o = |match_i;

endmodule

// File: rtl/pcie_xlat_unit.sv
module pcie_xlat_unit
  import pcie_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        lk_inbound,
  input  logic [63:0] lk_addr,
  output logic        lk_hit,
  output logic [3:0]  lk_win,
  output logic        lk_is_cfg,
  output logic [63:0] lk_out_addr,
  output logic [7:0]  lk_bus,
  output logic [7:0]  lk_devfn,
  output logic [11:0] lk_reg_off
);

  // named internal events for the checker
  logic [31:0]                  sel_q;
  win_live_t [1:0][NUM_WIN-1:0] live;
  logic      [1:0][NUM_WIN-1:0] commit;
  win_live_t [NUM_WIN-1:0]      dir_wins;
  logic      [NUM_WIN-1:0]      match;
  logic      [NUM_WIN-1:0]      grant;
  logic      [IDX_W-1:0]        win_idx;
  logic                         any_hit;
  win_live_t                    chosen;

  pcie_xlat_regs #(.NUM_WIN(NUM_WIN)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .sel_o    (sel_q),
    .live_o   (live),
    .commit_o (commit)
  );

  assign dir_wins = lk_inbound ? live[1] : live[0];

  pcie_xlat_match #(.NUM_WIN(NUM_WIN)) match_i (
    .wins    (dir_wins),
    .addr    (lk_addr),
    .match_o (match)
  );

  pcie_xlat_prio #(.NUM_WIN(NUM_WIN)) prio_i (
    .match_i (match),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (any_hit)
  );

  always_comb begin
    chosen = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant[i]) chosen = dir_wins[i];
    end
  end

  always_comb begin
    lk_hit      = any_hit;
    lk_win      = any_hit ? win_idx : '0;
    lk_is_cfg   = any_hit && chosen.is_cfg;
    lk_out_addr = '0;
    lk_bus      = '0;
    lk_devfn    = '0;
    lk_reg_off  = '0;
    if (any_hit && !chosen.is_cfg) begin
      lk_out_addr = win_remap(chosen, lk_addr);
    end else if (any_hit) begin
      lk_bus     = chosen.target[31:24];
      lk_devfn   = chosen.target[23:16];
      lk_reg_off = win_cfg_off(chosen, lk_addr);
    end
  end

endmodule

// File: rtl/pcie_xlat_unit_chk.sv
module pcie_xlat_unit_chk
  import pcie_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_wr,
  input logic [11:0]                  cfg_addr,
  input logic                         lk_inbound,
  input logic [31:0]                  sel_q,
  input win_live_t [1:0][NUM_WIN-1:0] live,
  input logic      [1:0][NUM_WIN-1:0] commit,
  input logic      [NUM_WIN-1:0]      match,
  input logic      [NUM_WIN-1:0]      grant,
  input logic                         lk_hit,
  input logic [3:0]                   lk_win,
  input logic                         lk_is_cfg,
  input logic [63:0]                  lk_out_addr,
  input logic [7:0]                   lk_bus,
  input logic [7:0]                   lk_devfn,
  input logic [11:0]                  lk_reg_off
);

  logic [NUM_WIN-1:0] en_vec;
  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) en_vec[i] = live[lk_inbound ? 1 : 0][i].en;
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == OFF_SEL) |=> $stable(sel_q)); // R1

  AST_COMMIT_ON_CTRL2: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit) |-> (cfg_wr && cfg_addr == OFF_CTRL2 && $onehot(commit))); // R4

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit == '0) |=> $stable(live)); // R4

  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((grant & ~en_vec) == '0)); // R5

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~match) == '0) &&
    ((grant == '0) || (((grant - 1'b1) & match) == '0))); // R8

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_win == '0 && !lk_is_cfg && lk_out_addr == '0 &&
                 lk_bus == '0 && lk_devfn == '0 && lk_reg_off == '0)); // R11

endmodule

bind pcie_xlat_unit pcie_xlat_unit_chk #(.NUM_WIN(NUM_WIN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_addr    (cfg_addr),
  .lk_inbound  (lk_inbound),
  .sel_q       (sel_q),
  .live        (live),
  .commit      (commit),
  .match       (match),
  .grant       (grant),
  .lk_hit      (lk_hit),
  .lk_win      (lk_win),
  .lk_is_cfg   (lk_is_cfg),
  .lk_out_addr (lk_out_addr),
  .lk_bus      (lk_bus),
  .lk_devfn    (lk_devfn),
  .lk_reg_off  (lk_reg_off)
);

// File: tb/pcie_xlat_unit_tb_top.sv
`timescale 1ns/1ps
module pcie_xlat_unit_tb_top;

  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_inbound = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        lk_hit;
  logic [3:0]  lk_win;
  logic        lk_is_cfg;
  logic [63:0] lk_out_addr;
  logic [7:0]  lk_bus;
  logic [7:0]  lk_devfn;
  logic [11:0] lk_reg_off;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  pcie_xlat_unit #(.NUM_WIN(NW)) dut_i (.*);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic look(logic inb, logic [63:0] a);
    @(negedge clk);
    lk_inbound = inb; lk_addr = a;
    #1;
  endtask

  task automatic sel(logic inb, int idx);
    wr(12'h900, {inb, 27'd0, 4'(idx)});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h900, d);             chk("R1 sel reset", d, 0);
    sel(1'b0, 2);
    rd(12'h914, d);             chk("R10 limit reset", d, 32'hFFFF_FFFF);
    rd(12'h908, d);             chk("R10 out ctrl2 reset", d, 0);
    sel(1'b1, 0);
    rd(12'h908, d);             chk("R10 in0 ctrl2 reset", d, 32'h8000_0000);
    look(1'b1, 64'h1234_5678);
    chk("R10 inbound pass hit", lk_hit, 1);
    chk("R10 inbound pass addr", lk_out_addr, 64'h1234_5678);
    look(1'b0, 64'h1234_5678);
    chk("R11 outbound miss hit", lk_hit, 0);
    chk("R11 miss addr zero", lk_out_addr, 0);
  endtask

  task automatic t_mem_window;
    logic [31:0] d;
    sel(1'b0, 1);
    wr(12'h90C, 32'h1000_0000);
    wr(12'h910, 32'h0000_0002);
    wr(12'h914, 32'h1000_FFFF);
    wr(12'h918, 32'h8000_0000);
    wr(12'h904, 32'h0);
    look(1'b0, 64'h2_1000_1234);
    chk("R4 no hit before commit", lk_hit, 0);
    wr(12'h908, 32'h8000_0000);
    look(1'b0, 64'h2_1000_1234);
    chk("R6 mem hit", lk_hit, 1);
    chk("R6 mem idx", lk_win, 1);
    chk("R6 mem remap", lk_out_addr, 64'h8000_1234);
    chk("R6 mem not cfg", lk_is_cfg, 0);
    look(1'b0, 64'h2_1000_FFFF);
    chk("R5 top edge hit", lk_hit, 1);
    look(1'b0, 64'h2_1001_0000);
    chk("R5 past limit miss", lk_hit, 0);
    look(1'b0, 64'h2_0FFF_FFFF);
    chk("R5 below base miss", lk_hit, 0);
    look(1'b0, 64'h3_1000_0000);
    chk("R5 upper half differs miss", lk_hit, 0);
    rd(12'h910, d);             chk("R2 base high readback", d, 2);
  endtask

  task automatic t_halves;
    logic [31:0] d;
    sel(1'b0, 3);
    wr(12'h91C, 32'hAAAA_0001);
    wr(12'h918, 32'h5555_0002);
    rd(12'h91C, d);             chk("R3 target high kept", d, 32'hAAAA_0001);
    rd(12'h918, d);             chk("R3 target low", d, 32'h5555_0002);
    wr(12'h910, 32'h0000_0007);
    wr(12'h90C, 32'h0000_1000);
    rd(12'h910, d);             chk("R3 base high kept", d, 7);
    rd(12'h900, d);             chk("R1 sel readback", d, 3);
  endtask

  task automatic t_cfg_window;
    sel(1'b0, 2);
    wr(12'h90C, 32'h4000_0000);
    wr(12'h914, 32'h4FFF_FFFF);
    wr(12'h918, 32'h0312_0000);
    wr(12'h904, 32'h0000_0004);
    wr(12'h908, 32'h8000_0000);
    look(1'b0, 64'h4000_0A10);
    chk("R7 cfg hit", lk_hit, 1);
    chk("R7 cfg flag", lk_is_cfg, 1);
    chk("R7 bus", lk_bus, 8'h03);
    chk("R7 devfn", lk_devfn, 8'h12);
    chk("R7 offset", lk_reg_off, 12'hA10);
    chk("R7 no remap addr", lk_out_addr, 0);
    look(1'b0, 64'h4000_1A10);
    chk("R7 offset masked", lk_reg_off, 12'hA10);
    look(1'b1, 64'h4000_0A10);
    chk("R9 inbound ignores out cfg", lk_is_cfg, 0);
    chk("R9 inbound win0", lk_out_addr, 64'h4000_0A10);
  endtask

  task automatic t_priority;
    sel(1'b0, 0);
    wr(12'h90C, 32'h1000_0000);
    wr(12'h910, 32'h0000_0002);
    wr(12'h914, 32'h1FFF_FFFF);
    wr(12'h918, 32'h9000_0000);
    wr(12'h908, 32'h8000_0000);
    look(1'b0, 64'h2_1000_0010);
    chk("R8 lowest index wins", lk_win, 0);
    chk("R8 lowest remap", lk_out_addr, 64'h9000_0010);
    wr(12'h908, 32'h0);
    look(1'b0, 64'h2_1000_0010);
    chk("R4 disabled falls to win1", lk_win, 1);
    chk("R4 disabled remap", lk_out_addr, 64'h8000_0010);
  endtask

  task automatic t_uncommitted;
    logic [31:0] d;
    sel(1'b0, 1);
    wr(12'h918, 32'hC000_0000);
    rd(12'h918, d);             chk("R2 shadow readback", d, 32'hC000_0000);
    look(1'b0, 64'h2_1000_0020);
    chk("R4 live unchanged", lk_out_addr, 64'h8000_0020);
    wr(12'h908, 32'h8000_0000);
    look(1'b0, 64'h2_1000_0020);
    chk("R4 after commit", lk_out_addr, 64'hC000_0020);
  endtask

  task automatic t_out_of_range;
    logic [31:0] d;
    sel(1'b0, NW);
    wr(12'h914, 32'h0000_1234);
    wr(12'h908, 32'h8000_0000);
    rd(12'h914, d);             chk("R2 bad index reads 0", d, 0);
    rd(12'hABC, d);             chk("R2 unmapped reads 0", d, 0);
    sel(1'b0, 1);
    rd(12'h914, d);             chk("R2 win1 limit intact", d, 32'h1000_FFFF);
    look(1'b0, 64'h0000_0100);
    chk("R2 bad index no window", lk_hit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mem_window();
    t_halves();
    t_cfg_window();
    t_priority();
    t_uncommitted();
    t_out_of_range();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule